// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a watchdog peripheral that sits on a simple single-cycle register bus. A 32-bit down-counter runs from a programmable reload value. The first time the count runs out, the block flags an interrupt and starts the count again from the reload value. If software has still not acknowledged that interrupt when the count runs out a second time, and reset generation is enabled, the block raises a system reset request. Software services the watchdog by acknowledging the interrupt or by writing a new reload value. Either action restarts the countdown.

All writes to the reload, control and acknowledge registers are guarded by a lock. Writing a 32-bit key to the lock register opens them. Writing any other value to it closes them again. This keeps runaway code from disarming the watchdog. Read data comes back one cycle after the read strobe. The interrupt line and the reset request are driven straight from flip-flops.

Top module: `wdog_twostage`

## Requirements
- R1: After a synchronous reset the reload register (offset 0x000) and the counter (offset 0x004) both read 0xFFFFFFFF. The control register (0x008), raw status (0x010) and lock status (0xC00) read 0. `irq_o` and `rst_req_o` are low.
- R2: The counter drops by exactly one per clock while control bit 0 is 1. It holds its value while control bit 0 is 0.
- R3: When the counter is at zero with bit 0 of raw status clear and control bit 0 set, the next clock edge sets raw status bit 0 and reloads the counter. With reload value L, `irq_o` (raw flag AND control bit 0) rises L+1 clocks after the counter was loaded.
- R4: When the counter is at zero while raw status bit 0 is already set and control bit 1 is 1, `rst_req_o` rises at that edge, which is 2(L+1) clocks after the load. It then stays high until the block is reset. With control bit 1 at 0 the counter just reloads, and `rst_req_o` stays low.
- R5: An accepted write to offset 0x000 stores the value and loads it into the counter at the same edge. A written value of 0 is stored as 1.
- R6: An accepted write of any data to offset 0x00C clears raw status bit 0 and reloads the counter from the reload register.
- R7: Masked status (offset 0x014) bit 0 and `irq_o` both equal raw status bit 0 AND control bit 0.
- R8: Writing 0x1ACCE551 to offset 0xC00 unlocks the block, and any other value locks it. Reading 0xC00 returns 1 when locked and 0 when unlocked.
- R9: While the block is locked, writes to offsets 0x000, 0x008 and 0x00C have no effect.
- R10: A reload write or an acknowledge write that lands on the same edge as an expiry takes priority over it. The flag is not set, no reset is requested, and the counter takes the value the write selects.
- R11: Read data is valid on the cycle after the read strobe. Unmapped offsets and offset 0x00C read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid one cycle after the read strobe |
| irq_o | output | 1 | Watchdog interrupt |
| rst_req_o | output | 1 | Sticky reset request |

## Verification
Two kinds of event can land on the same clock edge: the counter expiring and a software write that services the watchdog. The bench counts cycles from the reload write and places an acknowledge write, or a new reload write, exactly on the edge where the counter sits at zero. It does this once at the first expiry and once at the second expiry with reset enabled. The outcome is judged by reading raw status, reading the counter value the write selected, and checking that no reset request appears. Sweeps over small reload values then check the exact L+1 and 2(L+1) timing.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  localparam logic [11:0] OFS_RELOAD = 12'h000;
  localparam logic [11:0] OFS_COUNT  = 12'h004;
  localparam logic [11:0] OFS_CTRL   = 12'h008;
  localparam logic [11:0] OFS_ACK    = 12'h00C;
  localparam logic [11:0] OFS_RAW    = 12'h010;
  localparam logic [11:0] OFS_MASKED = 12'h014;
  localparam logic [11:0] OFS_GUARD  = 12'hC00;

  // control bit 1 = reset generation, bit 0 = count and interrupt
  typedef struct packed {
    logic rst_en;
    logic run;
  } wd_ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
`timescale 1ns/1ps
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACCE551,
  parameter logic [DATA_W-1:0] LOAD_INIT  = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              flag_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] reload_o,
  output wd_ctrl_t          ctrl_o,
  output logic              reload_wr_o,
  output logic [DATA_W-1:0] reload_wdata_o,
  output logic              ack_o
);
  localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFS_RELOAD);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_ACK    = ADDR_W'(OFS_ACK);
  localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(OFS_RAW);
  localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(OFS_MASKED);
  localparam logic [ADDR_W-1:0] A_GUARD  = ADDR_W'(OFS_GUARD);
  localparam logic [DATA_W-1:0] ONE      = DATA_W'(1);

  logic [DATA_W-1:0] reload_q;
  wd_ctrl_t          ctrl_q;
  logic              locked_q;
  logic [DATA_W-1:0] rd_mux;
  logic              wr_stb, rd_stb;

  assign wr_stb = bus_sel && bus_wr;
  assign rd_stb = bus_sel && !bus_wr;

  assign reload_wr_o    = wr_stb && !locked_q && (bus_addr == A_RELOAD);
  assign reload_wdata_o = (bus_wdata == '0) ? ONE : bus_wdata;
  assign ack_o          = wr_stb && !locked_q && (bus_addr == A_ACK);
  assign reload_o       = reload_q;
  assign ctrl_o         = ctrl_q;

  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_RELOAD)      rd_mux = reload_q;
    else if (bus_addr == A_COUNT)  rd_mux = cnt_i;
    else if (bus_addr == A_CTRL)   rd_mux = {{(DATA_W-2){1'b0}}, ctrl_q};
    else if (bus_addr == A_RAW)    rd_mux = {{(DATA_W-1){1'b0}}, flag_i};
    else if (bus_addr == A_MASKED) rd_mux = {{(DATA_W-1){1'b0}}, flag_i & ctrl_q.run};
    else if (bus_addr == A_GUARD)  rd_mux = {{(DATA_W-1){1'b0}}, locked_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= LOAD_INIT;
      ctrl_q   <= '0;
      locked_q <= 1'b0;
      rdata_o  <= '0;
    end else begin
      if (reload_wr_o) reload_q <= reload_wdata_o;
      if (wr_stb && !locked_q && (bus_addr == A_CTRL)) ctrl_q <= wd_ctrl_t'(bus_wdata[1:0]);
      if (wr_stb && (bus_addr == A_GUARD)) locked_q <= (bus_wdata != UNLOCK_KEY);
      if (rd_stb) rdata_o <= rd_mux;
    end
  end

  // R9
  locked_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && locked_q && bus_addr == A_RELOAD) |=> $stable(reload_q));
  // R9
  locked_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && locked_q && bus_addr == A_CTRL) |=> $stable(ctrl_q));
  // R8
  key_open_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && bus_addr == A_GUARD && bus_wdata == UNLOCK_KEY) |=> !locked_q);
endmodule

// File: rtl/wdog_count.sv
`timescale 1ns/1ps
module wdog_count #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] LOAD_INIT = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              rst_en_i,
  input  logic [DATA_W-1:0] reload_i,
  input  logic              reload_wr_i,
  input  logic [DATA_W-1:0] reload_wdata_i,
  input  logic              ack_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              flag_o,
  output logic              rst_req_o
);
  logic [DATA_W-1:0] cnt_q;
  logic              flag_q;
  logic              rstreq_q;
  logic              at_zero;

  assign at_zero   = (cnt_q == '0);
  assign cnt_o     = cnt_q;
  assign flag_o    = flag_q;
  assign rst_req_o = rstreq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= LOAD_INIT;
      flag_q   <= 1'b0;
      rstreq_q <= 1'b0;
    end else if (reload_wr_i) begin
      cnt_q <= reload_wdata_i;
    end else if (ack_i) begin
      cnt_q  <= reload_i;
      flag_q <= 1'b0;
    end else if (run_i) begin
      if (at_zero) begin
        cnt_q <= reload_i;
        if (!flag_q)       flag_q   <= 1'b1;
        else if (rst_en_i) rstreq_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R4
  rst_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    rstreq_q |=> rstreq_q);
  // R4
  rst_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (!rstreq_q ##1 rstreq_q) |-> $past(flag_q && rst_en_i && at_zero));
  // R3
  flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (!flag_q ##1 flag_q) |-> $past(at_zero && run_i));
  // R10
  ack_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ack_i |=> (!flag_q && $stable(rstreq_q)));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !reload_wr_i && !ack_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_twostage.sv
`timescale 1ns/1ps
module wdog_twostage
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACCE551,
  parameter logic [DATA_W-1:0] LOAD_INIT  = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic [DATA_W-1:0] cnt, reload, reload_wdata;
  logic              flag, reload_wr, ack;
  wd_ctrl_t          ctrl;

  wdog_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .UNLOCK_KEY(UNLOCK_KEY), .LOAD_INIT(LOAD_INIT)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cnt_i(cnt), .flag_i(flag), .rdata_o(bus_rdata),
    .reload_o(reload), .ctrl_o(ctrl), .reload_wr_o(reload_wr),
    .reload_wdata_o(reload_wdata), .ack_o(ack)
  );

  wdog_count #(.DATA_W(DATA_W), .LOAD_INIT(LOAD_INIT)) u_count (
    .clk(clk), .rst(rst), .run_i(ctrl.run), .rst_en_i(ctrl.rst_en),
    .reload_i(reload), .reload_wr_i(reload_wr), .reload_wdata_i(reload_wdata),
    .ack_i(ack), .cnt_o(cnt), .flag_o(flag), .rst_req_o(rst_req_o)
  );

  assign irq_o = flag & ctrl.run;

  // R7
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ctrl.run);
endmodule

// File: tb/tb_wdog_twostage.sv
`timescale 1ns/1ps
module tb_wdog_twostage;
  localparam logic [11:0] A_RELOAD = 12'h000, A_COUNT = 12'h004, A_CTRL = 12'h008,
                          A_ACK = 12'h00C, A_RAW = 12'h010, A_MASKED = 12'h014,
                          A_GUARD = 12'hC00;
  localparam logic [31:0] KEY = 32'h1ACCE551;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst, bus_sel, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq_o, rst_req_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  wdog_twostage dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every task starts and ends just after a falling edge
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    rst = 1; idle(2); rst = 0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    rd(a, v);
    chk(v === exp, req, v, exp);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog timeout actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    rst = 1; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    @(negedge clk);
    do_reset();

    // R1 reset state
    chk(!irq_o && !rst_req_o, "R1 outputs", {30'b0, irq_o, rst_req_o}, 0);
    rd_chk(A_RELOAD, 32'hFFFFFFFF, "R1 reload");
    rd_chk(A_COUNT, 32'hFFFFFFFF, "R1 count");
    rd_chk(A_CTRL, 0, "R1 ctrl");
    rd_chk(A_RAW, 0, "R1 raw");
    rd_chk(A_GUARD, 0, "R1 lock");

    // R5 reload write and zero clamp
    wr(A_RELOAD, 0);
    rd_chk(A_RELOAD, 1, "R5 zero stored as one");
    wr(A_RELOAD, 32'h12345678);
    rd_chk(A_RELOAD, 32'h12345678, "R5 reload value");
    rd_chk(A_COUNT, 32'h12345678, "R5 counter loaded");

    // R2 hold and decrement
    wr(A_RELOAD, 100);
    rd_chk(A_COUNT, 100, "R2 held");
    idle(5);
    rd_chk(A_COUNT, 100, "R2 still held");
    wr(A_CTRL, 1);
    rd_chk(A_COUNT, 100, "R2 first sample");
    idle(3);
    rd_chk(A_COUNT, 96, "R2 decrement per clock");

    // R11 unmapped and ack offset read as zero
    rd_chk(12'h018, 0, "R11 unmapped");
    rd_chk(A_ACK, 0, "R11 ack offset");

    // R3 / R4 sweeps over small reload values
    for (int mode = 0; mode < 2; mode++) begin
      for (int L = 1; L <= 8; L++) begin
        do_reset();
        wr(A_CTRL, mode ? 3 : 1);
        wr(A_RELOAD, L);
        n = 0;
        while (!irq_o && n < 100) begin idle(1); n++; end
        chk(n == L + 1, "R3 first expiry period", n, L + 1);
        chk(!rst_req_o, "R4 no reset after first expiry", rst_req_o, 0);
        if (mode == 1) begin
          while (!rst_req_o && n < 100) begin idle(1); n++; end
          chk(n == 2 * (L + 1), "R4 second expiry reset", n, 2 * (L + 1));
          idle(L + 3);
          chk(rst_req_o, "R4 reset sticky", rst_req_o, 1);
        end else begin
          idle(2 * (L + 1));
          chk(!rst_req_o, "R4 no reset when disabled", rst_req_o, 0);
          rd_chk(A_RAW, 1, "R4 flag stays set");
        end
      end
    end

    // R7 masked status and R6 acknowledge
    do_reset();
    wr(A_CTRL, 1);
    wr(A_RELOAD, 3);
    idle(5);
    rd_chk(A_MASKED, 1, "R7 masked with run");
    wr(A_CTRL, 0);
    chk(!irq_o, "R7 irq masked", irq_o, 0);
    rd_chk(A_MASKED, 0, "R7 masked without run");
    rd_chk(A_RAW, 1, "R7 raw unaffected");
    wr(A_RELOAD, 6);
    wr(A_ACK, 0);
    rd_chk(A_RAW, 0, "R6 ack clears flag");
    rd_chk(A_COUNT, 6, "R6 ack reloads counter");

    // R8 lock register
    wr(A_GUARD, 1);
    rd_chk(A_GUARD, 1, "R8 locked");
    wr(A_GUARD, KEY);
    rd_chk(A_GUARD, 0, "R8 unlocked");
    wr(A_GUARD, KEY ^ 32'h1);
    rd_chk(A_GUARD, 1, "R8 near key locks");

    // R9 writes ignored while locked
    wr(A_RELOAD, 7);
    rd_chk(A_RELOAD, 6, "R9 reload ignored");
    wr(A_CTRL, 3);
    rd_chk(A_CTRL, 0, "R9 ctrl ignored");
    wr(A_GUARD, KEY);
    wr(A_CTRL, 1);
    wr(A_RELOAD, 2);
    wr(A_GUARD, 0);
    idle(4);
    rd_chk(A_RAW, 1, "R9 flag set while locked");
    wr(A_ACK, 1);
    rd_chk(A_RAW, 1, "R9 ack ignored");

    // R10 ack on the first expiry edge
    do_reset();
    wr(A_CTRL, 1);
    wr(A_RELOAD, 4);
    idle(4);
    wr(A_ACK, 0);
    rd_chk(A_RAW, 0, "R10 ack beats first expiry");
    rd_chk(A_COUNT, 3, "R10 counter after ack");
    // R10 reload write on the expiry edge
    wr(A_RELOAD, 4);
    idle(4);
    wr(A_RELOAD, 9);
    rd_chk(A_RAW, 0, "R10 reload beats expiry");
    rd_chk(A_COUNT, 8, "R10 counter after reload");
    // R10 ack on the second expiry edge with reset enabled
    do_reset();
    wr(A_CTRL, 3);
    wr(A_RELOAD, 4);
    idle(5);
    chk(irq_o, "R10 irq after first expiry", irq_o, 1);
    idle(4);
    wr(A_ACK, 0);
    chk(!rst_req_o, "R10 ack beats second expiry", rst_req_o, 0);
    idle(2);
    chk(!rst_req_o, "R10 no late reset", rst_req_o, 0);
    rd_chk(A_RAW, 0, "R10 flag cleared");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule